// File: doc/BRIEF.md
# Dual-Mode Stereo Serial Sample Receiver

This block sits in front of a two-channel audio DAC core. It takes 16-bit signed (two's complement) samples that arrive one bit per bit-clock cycle, MSB first, and presents them as a left and a right parallel word. The two channel outputs always change on the same clock edge, so the converter core sees the two channels of a sample pair in phase.

A static format input selects how the samples arrive. In one-line format a single data line carries left and right words one after the other. A frame clock marks which channel the current word belongs to, and its polarity can be chosen. In two-line format the left and right words travel on two data lines at the same time, and a falling edge of the frame clock marks the end of each pair. The block holds a left word until the matching right word is complete. It then waits a fixed four and a half bit-clock cycles and loads both outputs together, with a one-cycle strobe.

Data and the frame clock change on the falling edge of the bit clock and are captured on its rising edge. The bit clock may run all the time or stop between words. The framing edge may come at any point between the end of the LSB and the start of the next MSB.

Top module: `stereo_pair_rx`

## Requirements
- R1: While `rst_n` is low and after it is released, `left_word` and `right_word` are 0 and `pair_stb` is 0 until the first pair is released.
- R2: In one-line format (`two_line_mode`=0) each word on `sdata_a` is 16 bits, MSB first. A word ends when a rising bit-clock edge sees `frame_clk` at a level different from the level it had at the previous rising edge. The last 16 bits captured before that edge form the word.
- R3: In one-line format the channel of a word is set by the `frame_clk` level during the word. With `lr_polarity`=0, level 1 means left. With `lr_polarity`=1, level 0 means left. The other level means right.
- R4: In one-line format a completed left word is held. The next completed right word releases the pair (held left, that right). A right word that completes while no left word is held releases nothing.
- R5: In two-line format (`two_line_mode`=1) the left word comes on `sdata_a` and the right word on `sdata_b`. A pair ends only when a rising bit-clock edge sees `frame_clk` at 0 after seeing 1 at the previous rising edge. A rise of `frame_clk` has no effect.
- R6: Let N be the rising edge that captures the LSB of a released pair. Both outputs take the new pair on the falling edge that follows rising edge N+4. `pair_stb` is 1 from that falling edge to the next falling edge. The outputs change at no other time.
- R7: If the bit clock is stopped between the LSB and the next MSB, and the framing edge happens while it is stopped, framing and pairing work as in R2 to R5. The R6 latency is counted in rising bit-clock edges, not in time.
- R8: In one-line format `sdata_b` has no effect on `left_word`, `right_word` or `pair_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock; inputs captured on rising edge, outputs updated on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| two_line_mode | input | 1 | Format select: 0 one-line, 1 two-line (tie low when unused) |
| lr_polarity | input | 1 | One-line channel polarity select |
| frame_clk | input | 1 | Channel clock (one-line) or word clock (two-line) |
| sdata_a | input | 1 | Serial data: both channels (one-line) or left channel (two-line) |
| sdata_b | input | 1 | Serial data: right channel (two-line only) |
| left_word | output | 16 | Left channel sample, two's complement |
| right_word | output | 16 | Right channel sample, two's complement |
| pair_stb | output | 1 | One-cycle pulse marking a new output pair |

## Verification
The hardest case to reach from the ports is a stopped bit clock, where the framing edge falls in a gap with no clock edges and the release delay is spread across a pause in time. The bench gates its own clock generator low right after an LSB, moves the frame clock and the next MSB while the clock is stopped, and restarts the clock. It then checks that the outputs still change on the falling edge after the fourth rising edge counted from the LSB. The same sweep of word values runs with a free-running clock and with a gated clock, for both polarities and both formats. The first word after reset is a right word with no held left word, which checks that nothing is released.

// File: rtl/dacrx_pkg.sv
package dacrx_pkg;

    typedef enum logic {
        FMT_ONE_LINE = 1'b0,
        FMT_TWO_LINE = 1'b1
    } fmt_e;

    // A frame level marks a left word when it differs from the polarity select.
    function automatic logic level_is_left(input logic level, input logic pol);
        return level ^ pol;
    endfunction

endpackage

// File: rtl/dacrx_shift.sv
module dacrx_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    output logic [WORD_W-1:0] word_q
);
    typedef struct packed {
        logic [WORD_W-1:0] sr;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d    = sh_q;
        sh_d.sr = {sh_q.sr[WORD_W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign word_q = sh_q.sr;
endmodule

// File: rtl/dacrx_frame.sv
module dacrx_frame
    import dacrx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fmt_e              fmt,
    input  logic              lr_pol,
    input  logic              frame_in,
    input  logic [WORD_W-1:0] line_a_word,
    input  logic [WORD_W-1:0] line_b_word,
    output logic              pair_ok,
    output logic [WORD_W-1:0] pair_l,
    output logic [WORD_W-1:0] pair_r
);
    typedef struct packed {
        logic              primed;
        logic              hist;
        logic              held_v;
        logic [WORD_W-1:0] held;
    } fr_t;

    fr_t  fr_d, fr_q;
    logic toggled;
    logic fell;
    logic old_is_left;
    logic stage_load;

    always_comb begin
        fr_d        = fr_q;
        fr_d.primed = 1'b1;
        fr_d.hist   = frame_in;
        toggled     = fr_q.primed && (frame_in != fr_q.hist);
        fell        = toggled && fr_q.hist;
        old_is_left = level_is_left(fr_q.hist, lr_pol);
        pair_ok     = 1'b0;
        stage_load  = 1'b0;
        pair_l      = fr_q.held;
        pair_r      = line_a_word;
        if (fmt == FMT_TWO_LINE) begin
            fr_d.held_v = 1'b0;
            pair_l      = line_a_word;
            pair_r      = line_b_word;
            pair_ok     = fell;
        end else if (toggled) begin
            if (old_is_left) begin
                stage_load  = 1'b1;
                fr_d.held   = line_a_word;
                fr_d.held_v = 1'b1;
            end else if (fr_q.held_v) begin
                pair_ok     = 1'b1;
                fr_d.held_v = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    // R5: a two-line release only on a sampled high-to-low frame transition
    p_two_line_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_ok && fmt == FMT_TWO_LINE) |-> ($past(frame_in) && !frame_in));

    // R2: a one-line release only on a sampled frame level change
    p_one_line_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_ok && fmt == FMT_ONE_LINE) |-> (frame_in != $past(frame_in)));

    // R4: one completed word either stages a left or releases a pair, never both
    p_stage_or_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(pair_ok && stage_load));
endmodule

// File: rtl/dacrx_release.sv
module dacrx_release #(
    parameter int WORD_W    = 16,
    parameter int LAT_EDGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pair_ok,
    input  logic [WORD_W-1:0] pair_l,
    input  logic [WORD_W-1:0] pair_r,
    output logic [WORD_W-1:0] out_l,
    output logic [WORD_W-1:0] out_r,
    output logic              out_stb
);
    localparam int CW = $clog2(LAT_EDGES + 1);

    typedef struct packed {
        logic              busy;
        logic [CW-1:0]     cnt;
        logic              fire;
        logic [WORD_W-1:0] hl;
        logic [WORD_W-1:0] hr;
    } rl_t;

    typedef struct packed {
        logic              stb;
        logic [WORD_W-1:0] wl;
        logic [WORD_W-1:0] wr;
    } ot_t;

    rl_t rl_d, rl_q;
    ot_t ot_d, ot_q;

    // Rising-edge side: count the remaining edges of the latency window.
    always_comb begin
        rl_d      = rl_q;
        rl_d.fire = 1'b0;
        if (pair_ok) begin
            rl_d.busy = 1'b1;
            rl_d.cnt  = CW'(LAT_EDGES - 1);
            rl_d.hl   = pair_l;
            rl_d.hr   = pair_r;
        end else if (rl_q.busy) begin
            if (rl_q.cnt == CW'(1)) begin
                rl_d.fire = 1'b1;
                rl_d.busy = 1'b0;
            end
            rl_d.cnt = rl_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rl_q <= '0;
        else        rl_q <= rl_d;
    end

    // Falling-edge side: supplies the final half cycle of the latency.
    always_comb begin
        ot_d     = ot_q;
        ot_d.stb = rl_q.fire;
        if (rl_q.fire) begin
            ot_d.wl = rl_q.hl;
            ot_d.wr = rl_q.hr;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) ot_q <= '0;
        else        ot_q <= ot_d;
    end

    assign out_l   = ot_q.wl;
    assign out_r   = ot_q.wr;
    assign out_stb = ot_q.stb;

    // R6: the release request lasts exactly one rising-edge cycle
    p_fire_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rl_q.fire |=> !rl_q.fire);

    // R6: framing never delivers a new pair inside a running latency window
    p_pair_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ok |-> !rl_q.busy);

    // R6: channel outputs move only together with the strobe
    p_update_with_stb_r6: assert property (@(negedge clk) disable iff (!rst_n)
        ((ot_q.wl != $past(ot_q.wl)) || (ot_q.wr != $past(ot_q.wr))) |-> ot_q.stb);
endmodule

// File: rtl/stereo_pair_rx.sv
module stereo_pair_rx
    import dacrx_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int LAT_EDGES = 4
) (
    input  logic              clk_bit,
    input  logic              rst_n,
    input  logic              two_line_mode,
    input  logic              lr_polarity,
    input  logic              frame_clk,
    input  logic              sdata_a,
    input  logic              sdata_b,
    output logic [WORD_W-1:0] left_word,
    output logic [WORD_W-1:0] right_word,
    output logic              pair_stb
);
    localparam int LINES = 2;

    fmt_e              fmt;
    logic [LINES-1:0]  din_vec;
    logic [WORD_W-1:0] line_word [LINES];
    logic              pair_ok;
    logic [WORD_W-1:0] pair_l;
    logic [WORD_W-1:0] pair_r;

    assign fmt     = fmt_e'(two_line_mode);
    assign din_vec = {sdata_b, sdata_a};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        dacrx_shift #(.WORD_W(WORD_W)) u_shift (
            .clk    (clk_bit),
            .rst_n  (rst_n),
            .din    (din_vec[g]),
            .word_q (line_word[g])
        );
    end

    dacrx_frame #(.WORD_W(WORD_W)) u_frame (
        .clk         (clk_bit),
        .rst_n       (rst_n),
        .fmt         (fmt),
        .lr_pol      (lr_polarity),
        .frame_in    (frame_clk),
        .line_a_word (line_word[0]),
        .line_b_word (line_word[1]),
        .pair_ok     (pair_ok),
        .pair_l      (pair_l),
        .pair_r      (pair_r)
    );

    dacrx_release #(.WORD_W(WORD_W), .LAT_EDGES(LAT_EDGES)) u_release (
        .clk     (clk_bit),
        .rst_n   (rst_n),
        .pair_ok (pair_ok),
        .pair_l  (pair_l),
        .pair_r  (pair_r),
        .out_l   (left_word),
        .out_r   (right_word),
        .out_stb (pair_stb)
    );
endmodule

// File: tb/tb_stereo_pair_rx.sv
module tb_stereo_pair_rx;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        clk_en = 1'b1;
    logic        rst_n = 1'b0;
    logic        two_line_mode = 1'b0;
    logic        lr_polarity = 1'b0;
    logic        frame_clk = 1'b0;
    logic        sdata_a = 1'b0;
    logic        sdata_b = 1'b0;
    logic [15:0] left_word;
    logic [15:0] right_word;
    logic        pair_stb;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string scen = "R1";

    logic [15:0] q_l[$];
    logic [15:0] q_r[$];
    int          q_c[$];

    // bench model state
    logic        cur_lvl;
    logic [15:0] cur_w;
    int          cur_lsb;
    logic        st_v;
    logic [15:0] st_w;
    logic        p2_v;
    logic [15:0] p2_l, p2_r;
    int          p2_lsb;

    stereo_pair_rx dut (
        .clk_bit(clk), .rst_n(rst_n), .two_line_mode(two_line_mode),
        .lr_polarity(lr_polarity), .frame_clk(frame_clk),
        .sdata_a(sdata_a), .sdata_b(sdata_b),
        .left_word(left_word), .right_word(right_word), .pair_stb(pair_stb)
    );

    initial forever #(CLK_P/2) clk = clk_en ? ~clk : 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string what, input longint got, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", what, got, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    function automatic logic [15:0] pat(input int k);
        logic [15:0] b;
        case (k % 4)
            0:       b = 16'h7FFF;
            1:       b = 16'h8000;
            2:       b = 16'hFFFF;
            default: b = 16'h0001;
        endcase
        return b ^ 16'((k / 4) * 9313);
    endfunction

    // Output monitor: every strobe must match the next expected pair (R6 timing).
    initial forever begin
        @(posedge pair_stb);
        #1;
        if (q_l.size() == 0) begin
            chk(1'b0, {scen, " unexpected strobe"}, {left_word, right_word}, 0);
        end else begin
            logic [15:0] el, er;
            int ec;
            el = q_l.pop_front();
            er = q_r.pop_front();
            ec = q_c.pop_front();
            chk(left_word == el, {scen, " left word"}, left_word, el);
            chk(right_word == er, {scen, " right word"}, right_word, er);
            chk(cyc == ec + 4, {scen, " R6 latency in rising edges"}, cyc, ec + 4);
            chk(clk == 1'b0, "R6 update on falling edge", clk, 0);
            @(negedge clk);
            #1;
            chk(pair_stb == 1'b0, "R6 strobe lasts one cycle", pair_stb, 0);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sdata_a = 1'b0;
            sdata_b = 1'b1;
        end
    endtask

    task automatic do_reset(input logic mode, input logic pol, input logic lvl);
        @(negedge clk);
        rst_n = 1'b0;
        two_line_mode = mode;
        lr_polarity = pol;
        frame_clk = lvl;
        sdata_a = 1'b0;
        sdata_b = 1'b0;
        #1;
        chk(left_word == 16'h0 && right_word == 16'h0, "R1 outputs cleared in reset",
            {left_word, right_word}, 0);
        chk(pair_stb == 1'b0, "R1 strobe low in reset", pair_stb, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_lvl = lvl;
        cur_w = 16'h0;
        cur_lsb = 0;
        st_v = 1'b0;
        st_w = 16'h0;
        p2_v = 1'b0;
        idle(20);
        chk(left_word == 16'h0 && right_word == 16'h0 && pair_stb == 1'b0,
            "R1 outputs stay cleared after reset", {left_word, right_word, pair_stb}, 0);
    endtask

    // One-line word; sdata_b carries the inverse as noise (R8).
    task automatic word1(input logic [15:0] w, input logic lvl, input bit gap);
        if (lvl != cur_lvl) begin
            if (cur_lvl ^ lr_polarity) begin
                st_w = cur_w;
                st_v = 1'b1;
            end else if (st_v) begin
                q_l.push_back(st_w);
                q_r.push_back(cur_w);
                q_c.push_back(cur_lsb);
                st_v = 1'b0;
            end
        end
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (i == 0 && gap) begin
                clk_en = 1'b0;
                #(3*CLK_P + 2);
            end
            sdata_a = w[15-i];
            sdata_b = ~w[15-i] ^ i[0];
            frame_clk = lvl;
            clk_en = 1'b1;
        end
        @(posedge clk);
        #1;
        cur_lsb = cyc;
        cur_lvl = lvl;
        cur_w = w;
    endtask

    // Two-line pair; frame clock falls at the MSB and rises mid-word (R5).
    task automatic word2(input logic [15:0] wl, input logic [15:0] wr, input bit gap);
        if (p2_v) begin
            q_l.push_back(p2_l);
            q_r.push_back(p2_r);
            q_c.push_back(p2_lsb);
        end
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (i == 0 && gap) begin
                clk_en = 1'b0;
                #(3*CLK_P + 2);
            end
            sdata_a = wl[15-i];
            sdata_b = wr[15-i];
            frame_clk = (i >= 4);
            clk_en = 1'b1;
        end
        @(posedge clk);
        #1;
        p2_lsb = cyc;
        p2_l = wl;
        p2_r = wr;
        p2_v = 1'b1;
    endtask

    initial begin
        #(CLK_P * 150000);
        chk(1'b0, "watchdog expired", cyc, 0);
        report();
        $finish;
    end

    initial begin
        // One-line sweeps: both polarities, free-running and gated clock.
        for (int pol = 0; pol < 2; pol++) begin
            for (int g = 0; g < 2; g++) begin
                logic left_lvl;
                left_lvl = ~pol[0];
                scen = (g == 0) ? "R2/R3/R4/R8 one-line" : "R7/R3/R4 one-line gated";
                // idle at the right-channel level: first completion is an unpaired right word (R4)
                do_reset(1'b0, pol[0], pol[0]);
                for (int k = 0; k < 8; k++) begin
                    word1(pat(k), left_lvl, g[0]);
                    word1(pat(k + 9), ~left_lvl, g[0]);
                end
                word1(pat(3), left_lvl, g[0]);
                idle(8);
                chk(q_l.size() == 0, {scen, " all pairs released"}, q_l.size(), 0);
            end
        end
        // Two-line sweeps: free-running and gated clock.
        for (int g = 0; g < 2; g++) begin
            scen = (g == 0) ? "R5 two-line" : "R7/R5 two-line gated";
            do_reset(1'b1, 1'b0, 1'b0);
            for (int k = 0; k < 8; k++) begin
                word2(pat(k), pat(k + 5), g[0]);
            end
            word2(pat(1), pat(2), g[0]);
            idle(8);
            chk(q_l.size() == 0, {scen, " all pairs released"}, q_l.size(), 0);
        end
        report();
        $finish;
    end
endmodule